// File: doc/BRIEF.md
# Serial Decimal Digit Accumulator

This block reads a character stream, one 8-bit character on each clock where the valid strobe is high. It builds the binary value of every run of consecutive decimal digits. A two-state controller tracks whether a number is open. The first digit of a run loads its own value. Each later digit scales the running total by ten and adds the new digit. The scaling uses two shifted copies of the total and adders, with no multiplier.

The first non-digit character after a run closes the number. The block then raises a one-cycle completion pulse. The finished value stays on the output until the next run begins, so a consumer can read it at any time in between. A sticky flag shows whether any step of the current number went past the accumulator width. Typical uses are command parsers and text-protocol front ends that must turn ASCII numbers into integers at stream rate.

Top module: `dsa_stream_accum`

## Requirements
- R1: After reset, `num_done` is 0, `num_value` is 0 and `num_ovf` is 0.
- R2: A character is a digit only when its code lies in 0x30..0x39, and its digit value is the code minus 0x30. Codes 0x2F and 0x3A, and every other code, are non-digits.
- R3: A digit accepted while no number is open loads its value into `num_value` directly, whatever the earlier contents were, and clears `num_ovf`.
- R4: A digit accepted while a number is open sets `num_value` to ten times its previous value plus the digit, taken modulo 2^32.
- R5: A non-digit accepted while a number is open closes the number. `num_done` is then high for exactly the one cycle after the clock edge that accepts the character.
- R6: A non-digit accepted while no number is open raises no pulse and leaves `num_value` unchanged.
- R7: After a number closes, `num_value` and `num_ovf` hold the finished result until the first digit of the next number is accepted.
- R8: `num_ovf` becomes 1 when any scale-and-add step of the current number exceeds 2^32-1. It stays 1 until the next number starts.
- R9: A cycle with `in_valid` low changes neither `num_value` nor `num_ovf` nor the open/closed state, and produces no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; deassertion is synchronized inside |
| in_valid | input | 1 | Character strobe |
| in_char | input | 8 | Character code, ASCII |
| num_done | output | 1 | One-cycle pulse when a number closes |
| num_value | output | 32 | Running, then finished, binary value |
| num_ovf | output | 1 | Sticky overflow of the current number |

## Verification
The assertions assume that `in_valid` is never unknown after reset and that `in_char` holds a known code on every cycle where `in_valid` is high. They also assume that the input stream starts only after the internal reset release has passed through its two synchronizing flops. The stimulus drives both inputs from reset onward, changes them only on falling edges, and waits out the synchronizer before it sends the first character. Runs are placed next to the code boundaries 0x2F and 0x3A, next to 2^32-1, and across gaps in the strobe, so that each property is exercised with its antecedent true.

// File: rtl/dsa_pkg.sv
package dsa_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_NUM  = 1'b1
  } run_state_e;

  localparam int unsigned DIGIT_W = 4;
endpackage

// File: rtl/dsa_rst_sync.sv
module dsa_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/dsa_char_classify.sv
module dsa_char_classify #(
  parameter int unsigned            CHAR_W    = 8,
  parameter int unsigned            DIG_W     = 4,
  parameter logic [CHAR_W-1:0]      ZERO_CODE = CHAR_W'('h30)
) (
  input  logic [CHAR_W-1:0] char_i,
  output logic              is_digit_o,
  output logic [DIG_W-1:0]  digit_val_o
);
  localparam logic [CHAR_W-1:0] RADIX = CHAR_W'(10);

  logic [CHAR_W-1:0] offset;

  // One subtract plus one unsigned compare covers both range ends:
  // codes below ZERO_CODE wrap to large values.
  always_comb begin
    offset      = char_i - ZERO_CODE;
    is_digit_o  = (offset < RADIX);
    digit_val_o = offset[DIG_W-1:0];
  end
endmodule

// File: rtl/dsa_mul10_add.sv
module dsa_mul10_add #(
  parameter int unsigned ACC_W = 32,
  parameter int unsigned DIG_W = 4
) (
  input  logic [ACC_W-1:0] acc_i,
  input  logic [DIG_W-1:0] digit_i,
  output logic [ACC_W-1:0] sum_o,
  output logic             carry_o
);
  localparam int unsigned       EXT_W     = ACC_W + 4;
  localparam logic [ACC_W-1:0]  ALL_ONES  = '1;
  localparam logic [ACC_W-1:0]  OVF_FLOOR = (ALL_ONES - ACC_W'(9)) / ACC_W'(10) + ACC_W'(1);

  logic [EXT_W-1:0] ext;
  logic [EXT_W-1:0] wide;

  always_comb begin
    ext     = {4'b0000, acc_i};
    wide    = (ext << 1) + (ext << 3) + EXT_W'(digit_i);
    sum_o   = wide[ACC_W-1:0];
    carry_o = |wide[EXT_W-1:ACC_W];
  end

  // R8: an overflow can only come from a total at or above the smallest
  // value that, scaled by ten plus nine, leaves the accumulator range.
  always_comb begin
    p_ovf_floor_r8: assert (!carry_o || acc_i >= OVF_FLOOR);
  end
endmodule

// File: rtl/dsa_run_fsm.sv
module dsa_run_fsm
  import dsa_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       is_digit,
  output run_state_e state_o,
  output logic       load_first_o,
  output logic       accumulate_o,
  output logic       complete_o
);
  run_state_e state_q;
  run_state_e state_d;

  always_comb begin
    state_d      = state_q;
    load_first_o = 1'b0;
    accumulate_o = 1'b0;
    complete_o   = 1'b0;
    if (in_valid) begin
      unique case (state_q)
        ST_IDLE: begin
          if (is_digit) begin
            state_d      = ST_NUM;
            load_first_o = 1'b1;
          end
        end
        ST_NUM: begin
          if (is_digit) begin
            accumulate_o = 1'b1;
          end else begin
            state_d    = ST_IDLE;
            complete_o = 1'b1;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state_o = state_q;

  // R9: without a strobe the controller does not move.
  p_state_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> state_q == $past(state_q));
endmodule

// File: rtl/dsa_stream_accum.sv
module dsa_stream_accum
  import dsa_pkg::*;
#(
  parameter int unsigned CHAR_W = 8,
  parameter int unsigned ACC_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [CHAR_W-1:0] in_char,
  output logic              num_done,
  output logic [ACC_W-1:0]  num_value,
  output logic              num_ovf
);
  localparam int unsigned DW = DIGIT_W;

  logic             rst_sync_n;
  logic             is_digit;
  logic [DW-1:0]    digit_val;
  logic [ACC_W-1:0] next_sum;
  logic             next_carry;
  run_state_e       state;
  logic             load_first;
  logic             accumulate;
  logic             complete;

  logic [ACC_W-1:0] acc_q;
  logic             ovf_q;
  logic             done_q;

  dsa_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dsa_char_classify #(.CHAR_W(CHAR_W), .DIG_W(DW)) u_class (
    .char_i      (in_char),
    .is_digit_o  (is_digit),
    .digit_val_o (digit_val)
  );

  dsa_mul10_add #(.ACC_W(ACC_W), .DIG_W(DW)) u_mac (
    .acc_i   (acc_q),
    .digit_i (digit_val),
    .sum_o   (next_sum),
    .carry_o (next_carry)
  );

  dsa_run_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .in_valid     (in_valid),
    .is_digit     (is_digit),
    .state_o      (state),
    .load_first_o (load_first),
    .accumulate_o (accumulate),
    .complete_o   (complete)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)     acc_q <= '0;
    else if (load_first) acc_q <= ACC_W'(digit_val);
    else if (accumulate) acc_q <= next_sum;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)                   ovf_q <= 1'b0;
    else if (load_first)               ovf_q <= 1'b0;
    else if (accumulate && next_carry) ovf_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) done_q <= 1'b0;
    else             done_q <= complete;
  end

  assign num_value = acc_q;
  assign num_ovf   = ovf_q;
  assign num_done  = done_q;

  // R3: the first digit of a run replaces the total and clears the flag.
  p_first_load_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && is_digit && state == ST_IDLE)
    |=> (num_value == ACC_W'($past(digit_val)) && !num_ovf));

  // R4: without overflow the total never shrinks on a further digit.
  p_grow_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && is_digit && state == ST_NUM)
    |=> (num_ovf || num_value >= $past(num_value)));

  // R5: the completion pulse lasts one cycle.
  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    num_done |=> !num_done);

  // R5: a pulse follows only a non-digit that closed an open number.
  p_done_cause_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    num_done |-> $past(in_valid && !is_digit && state == ST_NUM));

  // R6: stray non-digits between numbers have no effect.
  p_idle_skip_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && !is_digit && state == ST_IDLE)
    |=> (!num_done && $stable(num_value) && $stable(num_ovf)));

  // R8: the flag is sticky until a new number starts.
  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (num_ovf && !(in_valid && is_digit && state == ST_IDLE)) |=> num_ovf);

  // R9: a cycle without the strobe leaves the outputs alone.
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> ($stable(num_value) && $stable(num_ovf) && !num_done));
endmodule

// File: tb/tb_dsa_stream_accum.sv
`timescale 1ns/1ps
module tb_dsa_stream_accum;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [7:0]  in_char;
  logic        num_done;
  logic [31:0] num_value;
  logic        num_ovf;

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  logic [31:0] q_val[$];
  logic        q_ovf[$];
  string       q_tag[$];

  // bench model state
  longint unsigned m_acc  = 0;
  bit              m_open = 0;
  bit              m_ovf  = 0;
  bit              prev_done = 0;

  dsa_stream_accum dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_char   (in_char),
    .num_done  (num_done),
    .num_value (num_value),
    .num_ovf   (num_ovf)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input longint unsigned act,
                       input longint unsigned exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // Driver: one accepted character per call; the model follows R2..R8.
  task automatic send(input logic [7:0] c);
    bit dig;
    @(negedge clk);
    in_valid = 1'b1;
    in_char  = c;
    dig = (c >= 8'h30) && (c <= 8'h39);
    if (dig) begin
      if (!m_open) begin
        m_acc  = longint'(c - 8'h30);
        m_ovf  = 0;
        m_open = 1;
      end else begin
        m_acc = m_acc * 10 + longint'(c - 8'h30);
        if (m_acc > 64'hFFFF_FFFF) m_ovf = 1;
        m_acc = m_acc & 64'hFFFF_FFFF;
      end
    end else if (m_open) begin
      m_open = 0;
      q_val.push_back(m_acc[31:0]);
      q_ovf.push_back(m_ovf);
      q_tag.push_back(m_ovf ? "R8" : "R4");
    end
  endtask

  task automatic send_str(input string s);
    for (int i = 0; i < s.len(); i++) send(s[i]);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_char  = 8'h00;
    end
  endtask

  // Monitor: pops one expected item per completion pulse.
  always @(negedge clk) begin
    if (rst_n && !ended) begin
      if (num_done && prev_done)
        check(1'b0, "R5 pulse longer than one cycle", 1, 0);
      if (num_done) begin
        if (q_val.size() == 0) begin
          check(1'b0, "R5/R6 unexpected pulse", 1, 0);
        end else begin
          logic [31:0] ev;
          logic        eo;
          string       et;
          ev = q_val.pop_front();
          eo = q_ovf.pop_front();
          et = q_tag.pop_front();
          check(num_value == ev, {et, " value"}, num_value, ev);
          check(num_ovf == eo, {et, " ovf"}, num_ovf, eo);
        end
      end
      prev_done = num_done;
    end
  end

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_char  = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check(num_done == 1'b0, "R1 done", num_done, 0);
    check(num_value == 32'd0, "R1 value", num_value, 0);
    check(num_ovf == 1'b0, "R1 ovf", num_ovf, 0);

    // R4/R5: multi-digit run closed by a space
    send_str("123 ");
    idle(1);
    check(num_value == 32'd123, "R4 run 123", num_value, 123);

    // R3: single digit replaces old contents
    send_str("7,");
    idle(2);
    check(num_value == 32'd7, "R3 first digit load", num_value, 7);

    // R6/R2: codes 0x2F and 0x3A between numbers are ignored
    send_str("/:");
    idle(2);
    check(num_value == 32'd7, "R6 idle non-digit keeps value", num_value, 7);
    check(num_done == 1'b0, "R6 no pulse", num_done, 0);

    // R2: boundaries 0 and 9 are digits, 0x2F and 0x3A close a run
    send_str("09/");
    send_str("90:");
    idle(2);
    check(num_value == 32'd90, "R2 boundary codes", num_value, 90);

    // R7: value held across stray characters and idle cycles
    send_str("#!");
    idle(3);
    check(num_value == 32'd90, "R7 hold after completion", num_value, 90);

    // R9: strobe gaps inside a number
    send_str("12");
    idle(1);
    check(num_value == 32'd12, "R9 partial value", num_value, 12);
    idle(3);
    check(num_value == 32'd12, "R9 gap hold", num_value, 12);
    check(num_done == 1'b0, "R9 no pulse in gap", num_done, 0);
    send_str("3;");
    idle(2);

    // R4: largest value without overflow
    send_str("4294967295 ");
    idle(1);
    check(num_ovf == 1'b0, "R4 max value no ovf", num_ovf, 0);

    // R8: just past the range, and far past the range
    send_str("4294967296 ");
    idle(1);
    check(num_ovf == 1'b1, "R8 ovf set", num_ovf, 1);
    send_str("99999999999,");
    idle(3);
    check(num_ovf == 1'b1, "R8 ovf held after close", num_ovf, 1);

    // R3/R8: a new number clears the flag
    send_str("5");
    idle(1);
    check(num_ovf == 1'b0, "R3 ovf cleared on new number", num_ovf, 0);
    check(num_value == 32'd5, "R3 load after overflow", num_value, 5);
    send_str("8 ");

    // R5: back-to-back numbers one character apart
    send_str("1 2 3 ");
    idle(4);

    check(q_val.size() == 0, "R5 all numbers completed", q_val.size(), 0);
    finish_run();
  end
endmodule